// File: doc/BRIEF.md
# Dual-Register Memory Bank Selector

This block sits next to an 8-bit processor with a 16-bit address bus and extends its reach to sixteen banks of 64KB by driving a 4-bit bank number. It keeps two 4-bit bank registers:

- The run bank register supplies the bank number in every ordinary cycle.
- The indirect bank register supplies it only while the processor's sequencer raises a transfer strobe. That strobe marks the data-transfer cycle of the designated indirect load or store instructions.

The bank number switches for that single cycle and falls back to the run bank on the next cycle with no added delay.

Software loads the registers with ordinary bus writes:

- A write to address 0x0000 loads the run bank register.
- A write to address 0x0001 loads the indirect bank register.

Reads of either address return the stored value.

An active-low address-enable input floats the processor's address, data and read/write lines, for example while another master uses the bus. The block passes these lines through and lowers a drive-enable output while they are floated. The bank number is never floated.

Top module: `bank_selector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both registers are set to 4'hF. After reset, `bank` reads 4'hF with the strobe low and with the strobe high.
- R2: A bus write (`cpu_valid`=1, `cpu_rw`=0) to address 0x0000 stores `cpu_wdata[3:0]` in the run bank register. The new value appears on `bank` from the next cycle on. The write cycle itself still shows the old value.
- R3: A bus write to address 0x0001 stores `cpu_wdata[3:0]` in the indirect bank register. The new value is visible from the next cycle on.
- R4: While `ind_xfer` is 0, `bank` equals the run bank register.
- R5: While `ind_xfer` is 1, `bank` equals the indirect bank register in that same cycle. In the next cycle with `ind_xfer` at 0, `bank` equals the run bank register again.
- R6: A bus read (`cpu_rw`=1) of 0x0000 or 0x0001 sets `reg_hit`=1 and returns the matching register in `reg_rdata[3:0]`, with `reg_rdata[7:4]`=0. For any other address, `reg_hit`=0 and `reg_rdata`=0.
- R7: The registers are unchanged by reads, by writes to any other address, and by cycles with `cpu_valid`=0.
- R8: When a write to 0x0001 coincides with `ind_xfer`=1, `bank` shows the old indirect value in that cycle and the new value in the next strobed cycle.
- R9: `bus_drive` equals the inverse of `addr_en_n`. `bus_addr`, `bus_wdata` and `bus_rw` always mirror the processor lines. `bank` does not depend on `addr_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor bus cycle is active |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| ind_xfer | input | 1 | Strobe marking the indirect data-transfer cycle |
| addr_en_n | input | 1 | Active-low address enable; high floats the bus lines |
| bank | output | 4 | Bank number, never floated |
| reg_hit | output | 1 | Current read targets a bank register |
| reg_rdata | output | 8 | Read data for the bank registers |
| bus_drive | output | 1 | 1 = pads drive address, data and read/write |
| bus_addr | output | 16 | Address toward the pads |
| bus_wdata | output | 8 | Write data toward the pads |
| bus_rw | output | 1 | Read/write toward the pads |

## Verification
The main function is tried with several stimulus patterns, each of which tells a different fault apart:

- Strobe-free runs show whether `bank` tracks the run bank register at all.
- Isolated strobe pulses between writes show whether the switch lasts exactly one cycle and whether the two registers are kept apart.
- A write to the indirect register in the same cycle as the strobe separates a write that takes effect that cycle from one that takes effect a cycle later.
- Random mixes of reads, writes to the two register addresses and to nearby addresses, idle cycles and address-enable toggling expose decoding that is too loose or too narrow.
- The same random mixes show any coupling between the address enable and the bank number.

// File: rtl/bank_sel_pkg.sv
// Package: shared types for the bank selector.
// Assumes: only two bank registers exist, so the select code is three-valued.
package bank_sel_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RUN  = 2'd1,
        SEL_IND  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/bank_addr_decode.sv
// Module: decodes the processor bus into register selects and write pulses.
// Assumes: the two register addresses differ; a write is a valid cycle with rw low.
module bank_addr_decode
    import bank_sel_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int RUN_ADDR = 0,
    parameter int IND_ADDR = 1
) (
    input  logic              cpu_valid,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    output reg_sel_e          sel,
    output logic              run_wr,
    output logic              ind_wr
);

    localparam logic [ADDR_W-1:0] RUN_A = ADDR_W'(RUN_ADDR);
    localparam logic [ADDR_W-1:0] IND_A = ADDR_W'(IND_ADDR);

    // Match the address against the two register locations.
    always_comb begin
        if (cpu_addr == RUN_A)      sel = SEL_RUN;
        else if (cpu_addr == IND_A) sel = SEL_IND;
        else                        sel = SEL_NONE;
    end

    // Form write pulses only for valid write cycles.
    always_comb begin
        run_wr = cpu_valid && !cpu_rw && (sel == SEL_RUN);
        ind_wr = cpu_valid && !cpu_rw && (sel == SEL_IND);
    end

endmodule

// File: rtl/bank_regfile.sv
// Module: holds the run and indirect bank registers.
// Assumes: synchronous active-low reset; writes land at the clock edge, so
// readers see the new value from the following cycle.
module bank_regfile #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_wr,
    input  logic              ind_wr,
    input  logic [BANK_W-1:0] wr_bank,
    output logic [BANK_W-1:0] run_q,
    output logic [BANK_W-1:0] ind_q
);

    localparam int NREG = 2;
    localparam logic [BANK_W-1:0] TOP_BANK = {BANK_W{1'b1}};

    logic [NREG-1:0]   wr_en;
    logic [BANK_W-1:0] regs [NREG];

    // Gather the write enables by register index (0 = run, 1 = indirect).
    always_comb begin
        wr_en = {ind_wr, run_wr};
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Load one bank register, resetting it to the top bank.
        always_ff @(posedge clk) begin
            if (!rst_n)        regs[g] <= TOP_BANK;
            else if (wr_en[g]) regs[g] <= wr_bank;
        end
    end

    // Expose the registers under their roles.
    always_comb begin
        run_q = regs[0];
        ind_q = regs[1];
    end

endmodule

// File: rtl/bank_out_stage.sv
// Module: selects the bank output, builds the register read data and passes the
// bus lines to the pads with a drive enable.
// Assumes: DATA_W > BANK_W; pads float when bus_drive is low; the bank output has
// no float control.
module bank_out_stage
    import bank_sel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              ind_xfer,
    input  logic              addr_en_n,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  reg_sel_e          sel,
    input  logic [BANK_W-1:0] run_q,
    input  logic [BANK_W-1:0] ind_q,
    output logic [BANK_W-1:0] bank,
    output logic              reg_hit,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_drive,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rw
);

    localparam int PAD_W = DATA_W - BANK_W;

    // Pick the indirect register only during the strobed transfer cycle.
    always_comb begin
        bank = ind_xfer ? ind_q : run_q;
    end

    // Return the selected register zero-extended on reads.
    always_comb begin
        reg_hit   = cpu_rw && (sel != SEL_NONE);
        reg_rdata = '0;
        if (cpu_rw) begin
            case (sel)
                SEL_RUN: reg_rdata = {{PAD_W{1'b0}}, run_q};
                SEL_IND: reg_rdata = {{PAD_W{1'b0}}, ind_q};
                default: reg_rdata = '0;
            endcase
        end
    end

    // Forward the bus lines; the address enable only gates pad drive.
    always_comb begin
        bus_drive = !addr_en_n;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        bus_rw    = cpu_rw;
    end

endmodule

// File: rtl/bank_selector.sv
// Module: top of the bank selector. Wires the decoder, register file and output
// stage together.
// Assumes: a single clock; the strobe comes from the processor sequencer and is
// high for exactly the data-transfer cycle of an indirect load or store.
module bank_selector
    import bank_sel_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter int RUN_ADDR = 0,
    parameter int IND_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              ind_xfer,
    input  logic              addr_en_n,
    output logic [BANK_W-1:0] bank,
    output logic              reg_hit,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_drive,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rw
);

    reg_sel_e          sel;
    logic              run_wr;
    logic              ind_wr;
    logic [BANK_W-1:0] run_q;
    logic [BANK_W-1:0] ind_q;

    bank_addr_decode #(
        .ADDR_W  (ADDR_W),
        .RUN_ADDR(RUN_ADDR),
        .IND_ADDR(IND_ADDR)
    ) u_decode (
        .cpu_valid(cpu_valid),
        .cpu_rw   (cpu_rw),
        .cpu_addr (cpu_addr),
        .sel      (sel),
        .run_wr   (run_wr),
        .ind_wr   (ind_wr)
    );

    bank_regfile #(
        .BANK_W(BANK_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_wr (run_wr),
        .ind_wr (ind_wr),
        .wr_bank(cpu_wdata[BANK_W-1:0]),
        .run_q  (run_q),
        .ind_q  (ind_q)
    );

    bank_out_stage #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .BANK_W(BANK_W)
    ) u_out (
        .ind_xfer (ind_xfer),
        .addr_en_n(addr_en_n),
        .cpu_rw   (cpu_rw),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .sel      (sel),
        .run_q    (run_q),
        .ind_q    (ind_q),
        .bank     (bank),
        .reg_hit  (reg_hit),
        .reg_rdata(reg_rdata),
        .bus_drive(bus_drive),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rw   (bus_rw)
    );

endmodule

// File: rtl/bank_selector_chk.sv
// Module: port-level properties of the bank selector, bound to the top module.
// Assumes: reset is held for at least one rising edge at start-up.
module bank_selector_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter int RUN_ADDR = 0,
    parameter int IND_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_rw,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [BANK_W-1:0] wr_bank,
    input logic              ind_xfer,
    input logic              addr_en_n,
    input logic [BANK_W-1:0] bank,
    input logic              reg_hit,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              bus_drive
);

    logic run_w;
    logic ind_w;
    logic is_reg;

    // Independent decode of writes and register hits from the ports.
    always_comb begin
        run_w  = cpu_valid && !cpu_rw && (cpu_addr == ADDR_W'(RUN_ADDR));
        ind_w  = cpu_valid && !cpu_rw && (cpu_addr == ADDR_W'(IND_ADDR));
        is_reg = (cpu_addr == ADDR_W'(RUN_ADDR)) || (cpu_addr == ADDR_W'(IND_ADDR));
    end

    // R2: a run-bank write is visible in the next unstrobed cycle.
    a_r2_run_write_next: assert property (@(posedge clk) disable iff (!rst_n)
        run_w |=> (ind_xfer || bank == $past(wr_bank)));

    // R3: an indirect write is visible in the next strobed cycle.
    a_r3_ind_write_next: assert property (@(posedge clk) disable iff (!rst_n)
        ind_w |=> (!ind_xfer || bank == $past(wr_bank)));

    // R4/R5: with no run write and no strobe, the unstrobed bank holds its value.
    a_r4_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ind_xfer && !run_w) |=> (ind_xfer || $stable(bank)));

    // R6: the upper read bits stay zero, and nothing is returned off-register.
    a_r6_read_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:BANK_W] == '0);

    a_r6_hit_decode: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit == (cpu_rw && is_reg));

    // R9: the pads are driven exactly when the address enable is low.
    a_r9_drive_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive != addr_en_n);

endmodule

bind bank_selector bank_selector_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BANK_W  (BANK_W),
    .RUN_ADDR(RUN_ADDR),
    .IND_ADDR(IND_ADDR)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_valid(cpu_valid),
    .cpu_rw   (cpu_rw),
    .cpu_addr (cpu_addr),
    .wr_bank  (cpu_wdata[BANK_W-1:0]),
    .ind_xfer (ind_xfer),
    .addr_en_n(addr_en_n),
    .bank     (bank),
    .reg_hit  (reg_hit),
    .reg_rdata(reg_rdata),
    .bus_drive(bus_drive)
);

// File: tb/test_bank_selector.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// reference model of the two bank registers kept in the bench.
module test_bank_selector;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid;
    logic        cpu_rw;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        ind_xfer;
    logic        addr_en_n;
    logic [3:0]  bank;
    logic        reg_hit;
    logic [7:0]  reg_rdata;
    logic        bus_drive;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rw;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_run;
    logic [3:0] m_ind;
    bit done = 0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    bank_selector i_bank_selector (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ind_xfer(ind_xfer),
        .addr_en_n(addr_en_n), .bank(bank), .reg_hit(reg_hit),
        .reg_rdata(reg_rdata), .bus_drive(bus_drive), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rw(bus_rw)
    );

    function automatic logic [3:0] exp_bank(input logic xf);
        return xf ? m_ind : m_run;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic rw, input logic [15:0] a);
        if (!rw) return 8'h00;
        if (a == 16'h0000) return {4'h0, m_run};
        if (a == 16'h0001) return {4'h0, m_ind};
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the outputs, then update the model.
    task automatic cyc(input logic v, input logic rw, input logic [15:0] a,
                       input logic [7:0] d, input logic xf, input logic aen);
        cpu_valid = v; cpu_rw = rw; cpu_addr = a; cpu_wdata = d;
        ind_xfer = xf; addr_en_n = aen;
        #1;
        check(bank == exp_bank(xf), xf ? "R5 strobed bank" : "R4 unstrobed bank",
              32'(bank), 32'(exp_bank(xf)));
        check(reg_rdata == exp_rdata(rw, a), "R6 read data",
              32'(reg_rdata), 32'(exp_rdata(rw, a)));
        check(reg_hit == (rw && (a == 16'h0000 || a == 16'h0001)), "R6 hit",
              32'(reg_hit), 32'(rw && (a == 16'h0000 || a == 16'h0001)));
        check(bus_drive == !aen && bus_addr == a && bus_wdata == d && bus_rw == rw,
              "R9 bus pass-through", {15'd0, bus_drive, bus_addr}, {15'd0, !aen, a});
        @(posedge clk);
        if (v && !rw && a == 16'h0000) m_run = d[3:0];
        if (v && !rw && a == 16'h0001) m_ind = d[3:0];
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0b4c));
        rst_n = 1'b0; cpu_valid = 0; cpu_rw = 1; cpu_addr = 0; cpu_wdata = 0;
        ind_xfer = 0; addr_en_n = 0;
        m_run = 4'hF; m_ind = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: the reset state shows the top bank with and without the strobe.
        #1;
        check(bank == 4'hF, "R1 reset run bank", 32'(bank), 32'hF);
        ind_xfer = 1; #1;
        check(bank == 4'hF, "R1 reset ind bank", 32'(bank), 32'hF);
        ind_xfer = 0;
        @(negedge clk);
        cyc(1, 1, 16'h0000, 8'h00, 0, 0);

        // R2: the write cycle shows the old value, the next cycle the new one.
        cyc(1, 0, 16'h0000, 8'hA3, 0, 0);
        cyc(0, 1, 16'h1234, 8'h00, 0, 0);
        check(m_run == 4'h3, "R2 run write low nibble", 32'(m_run), 32'h3);

        // R3: load the indirect register and read it back.
        cyc(1, 0, 16'h0001, 8'h57, 0, 0);
        cyc(1, 1, 16'h0001, 8'h00, 0, 0);

        // R5: a single strobe, then revert with no delay.
        cyc(1, 0, 16'h4000, 8'h00, 1, 0);
        cyc(1, 0, 16'h4001, 8'h00, 0, 0);

        // R8: a write to the indirect register during the strobe uses the old value.
        cyc(1, 0, 16'h0001, 8'hC9, 1, 0);
        cyc(0, 1, 16'h0000, 8'h00, 1, 0);

        // R7: reads, neighbour addresses and invalid cycles leave both registers alone.
        cyc(1, 0, 16'h0002, 8'h11, 0, 0);
        cyc(1, 0, 16'h0100, 8'h22, 1, 0);
        cyc(0, 0, 16'h0000, 8'h33, 0, 0);
        cyc(1, 1, 16'h0001, 8'h44, 1, 0);
        cyc(1, 1, 16'h0000, 8'h00, 0, 0);
        check(m_run == 4'h3 && m_ind == 4'h9, "R7 registers unchanged",
              {24'd0, m_run, m_ind}, 32'h39);

        // R9: the address enable floats the bus but never the bank number.
        cyc(1, 1, 16'hBEEF, 8'h5A, 0, 1);
        cyc(1, 1, 16'hBEEF, 8'h5A, 1, 1);

        // Seeded random traffic covering all of R2..R9.
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int pick = int'($urandom_range(0, 9));
            if (pick < 3)       a = 16'h0000;
            else if (pick < 6)  a = 16'h0001;
            else if (pick < 8)  a = 16'(int'($urandom_range(2, 3)));
            else                a = 16'($urandom);
            cyc(logic'($urandom_range(0, 4) != 0), logic'($urandom_range(0, 1)), a,
                8'($urandom), logic'($urandom_range(0, 3) == 0),
                logic'($urandom_range(0, 5) == 0));
        end

        // R1: a mid-run reset returns both registers to the top bank.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_run = 4'hF; m_ind = 4'hF;
        cyc(1, 1, 16'h0001, 8'h00, 1, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule